// File: doc/BRIEF.md
# Charging Port Handshake Controller

This block sits beside one downstream port of a hub and turns it from a plain data port into a port that can supply more charging current. A portable device that wants to charge raises a voltage on D+. An analog comparator reports this level on `dp_det`. The controller answers by enabling a voltage source on D- (`dm_src_en`) and counts how many cycles the device keeps D+ raised. If the device drops D+ within a window of cycles set by parameters, the exchange counts as a success. The controller then raises `neg_done` and publishes a current-limit code. That code depends on the speed the device later runs at.

A second operating mode serves a port that only charges. In that mode the controller asserts a control that shorts D+ to D-. It grants the highest current and does no handshake at all. The block runs from one clock and one active-low reset. The analog comparator, the sources and the short switch sit outside the block. Bus suspend does not stop charging service.

Top module: `chg_port_ctrl`

## Requirements
- R1: During and directly after reset, `dm_src_en`, `neg_done`, `dpdm_short` are 0 and `cur_code` is 2'b00.
- R2: With `port_en`, `chg_en` and `dev_attached` high and `ded_mode` low, a clock edge that samples `dp_det` high in the idle or granted state sets `dm_src_en` to 1 in the following cycle.
- R3: `dm_src_en` falls in the cycle after an edge that samples `dp_det` low. While D+ stays high, `dm_src_en` stays on for at most HOLD_MAX cycles.
- R4: While `chg_en` is low, `dm_src_en` stays 0, `neg_done` stays 0 and `cur_code` stays 2'b00, whatever `dp_det` does.
- R5: Let P be the number of consecutive edges that sample `dp_det` high. If MIN_W <= P <= MAX_W, `neg_done` is 1 from the cycle after the edge that samples `dp_det` low. A shorter pulse returns the block to idle with no grant. A pulse still high on edge MAX_W+1 is rejected with no grant, and no new handshake starts until `dp_det` has been seen low.
- R6: `cur_code` encoding: 2'b00 means no extra current; 2'b01 means 900 mA, shown after a successful handshake while `dev_hs` is 1; 2'b10 means 1.5 A, shown after a successful handshake while `dev_hs` is 0. The code follows `dev_hs` without delay.
- R7: With `port_en` high and `ded_mode` high, the block goes to dedicated mode in the next cycle, even if `chg_en` is high. In that mode `dpdm_short` is 1, `cur_code` is 2'b10, and `dm_src_en` and `neg_done` are 0. `dp_det` has no effect there.
- R8: D+ is watched the whole time charging is enabled. A new D+ level after a grant clears the grant in the next cycle and starts a fresh handshake.
- R9: An edge that samples `port_en` low, or `dev_attached` low outside dedicated mode, returns the block to idle. The grant is cleared in the next cycle.
- R10: `bus_susp` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enabled |
| chg_en | input | 1 | Charging handshake mode enabled |
| ded_mode | input | 1 | Dedicated charge-only mode |
| dev_attached | input | 1 | Device present on the port |
| dp_det | input | 1 | Comparator: device source level on D+ |
| dev_hs | input | 1 | Device runs at high speed |
| bus_susp | input | 1 | Bus suspended (no effect on charging) |
| dm_src_en | output | 1 | Enable for the D- voltage source |
| neg_done | output | 1 | Handshake finished successfully |
| cur_code | output | 2 | Allowed current: 00 none, 01 900 mA, 10 1.5 A |
| dpdm_short | output | 1 | Short D+ to D- (dedicated mode) |

## Verification
A wrong pulse count shows up in the cycle after D+ falls. It appears as a missing or spurious `neg_done`, so pulse widths at MIN_W-1, MIN_W, MAX_W and MAX_W+1 each expose an off-by-one on the first cycle that matters. A stuck or wrong state shows as `dm_src_en` still high one cycle after D+ falls, or past HOLD_MAX. It can also show as a grant that survives a detach or a disable by one cycle, or as a short active outside dedicated mode. The speed-dependent code is compared live as `dev_hs` toggles while the grant is held.

// File: rtl/chg_pkg.sv
package chg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_REJ,
        ST_DONE,
        ST_DED
    } chg_state_e;

    localparam logic [1:0] CUR_NONE = 2'b00;
    localparam logic [1:0] CUR_900  = 2'b01;
    localparam logic [1:0] CUR_1500 = 2'b10;
endpackage

// File: rtl/chg_pulse_timer.sv
module chg_pulse_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(1);
        else if (run && cnt_q != CNT_TOP)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/chg_grant.sv
module chg_grant
    import chg_pkg::*;
(
    input  logic       grant_chg,
    input  logic       grant_ded,
    input  logic       dev_hs,
    output logic [1:0] cur_code
);
    always_comb begin
        if (grant_ded)
            cur_code = CUR_1500;
        else if (grant_chg)
            cur_code = dev_hs ? CUR_900 : CUR_1500;
        else
            cur_code = CUR_NONE;
    end
endmodule

// File: rtl/chg_port_ctrl.sv
module chg_port_ctrl
    import chg_pkg::*;
#(
    parameter int MIN_W    = 4,
    parameter int HOLD_MAX = 12,
    parameter int MAX_W    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_en,
    input  logic       chg_en,
    input  logic       ded_mode,
    input  logic       dev_attached,
    input  logic       dp_det,
    input  logic       dev_hs,
    input  logic       bus_susp,
    output logic       dm_src_en,
    output logic       neg_done,
    output logic [1:0] cur_code,
    output logic       dpdm_short
);
    localparam int CW = $clog2(MAX_W + 2);
    localparam logic [CW-1:0] MIN_C  = CW'(MIN_W);
    localparam logic [CW-1:0] MAX_C  = CW'(MAX_W);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD_MAX);

    typedef struct packed {
        chg_state_e st;
    } ctrl_t;

    ctrl_t         ctl_d, ctl_q;
    logic          tmr_start, tmr_run;
    logic [CW-1:0] pulse_cnt;
    logic          susp_unused;

    // Suspend deliberately does not gate charging service.
    assign susp_unused = bus_susp;

    chg_pulse_timer #(.CW(CW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (tmr_run),
        .cnt   (pulse_cnt)
    );

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        tmr_run   = 1'b0;
        if (!port_en) begin
            ctl_d.st = ST_IDLE;
        end else if (ded_mode) begin
            ctl_d.st = ST_DED;
        end else if (!chg_en || !dev_attached) begin
            ctl_d.st = ST_IDLE;
        end else begin
            case (ctl_q.st)
                ST_IDLE, ST_DED, ST_DONE: begin
                    if (dp_det) begin
                        ctl_d.st  = ST_SRC;
                        tmr_start = 1'b1;
                    end else if (ctl_q.st == ST_DED) begin
                        ctl_d.st = ST_IDLE;
                    end
                end
                ST_SRC: begin
                    if (!dp_det)
                        ctl_d.st = (pulse_cnt >= MIN_C && pulse_cnt <= MAX_C)
                                   ? ST_DONE : ST_IDLE;
                    else if (pulse_cnt >= MAX_C)
                        ctl_d.st = ST_REJ;
                    else
                        tmr_run = 1'b1;
                end
                ST_REJ: begin
                    if (!dp_det) ctl_d.st = ST_IDLE;
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE};
        else        ctl_q <= ctl_d;
    end

    assign dm_src_en  = (ctl_q.st == ST_SRC) && (pulse_cnt <= HOLD_C);
    assign neg_done   = (ctl_q.st == ST_DONE);
    assign dpdm_short = (ctl_q.st == ST_DED);

    chg_grant grant_i (
        .grant_chg (neg_done),
        .grant_ded (dpdm_short),
        .dev_hs    (dev_hs),
        .cur_code  (cur_code)
    );

    AST_DM_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en |=> !dm_src_en); // R4
    AST_DM_DROPS_AFTER_DP: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_src_en && !dp_det) |=> !dm_src_en); // R3
    AST_DONE_AFTER_DP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(neg_done) |-> $past(!dp_det)); // R5
    AST_HS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_done && dev_hs) |-> cur_code == CUR_900); // R6
    AST_SHORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dm_src_en, neg_done, dpdm_short})); // R7
    AST_DETACH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_attached && !ded_mode) |=> cur_code == CUR_NONE); // R9
    AST_PORT_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (cur_code == CUR_NONE && !dpdm_short)); // R9
endmodule

// File: tb/chg_port_ctrl_tb_top.sv
module chg_port_ctrl_tb_top;
    localparam int MIN_W    = 4;
    localparam int HOLD_MAX = 12;
    localparam int MAX_W    = 16;
    localparam int NV       = 9;
    // pulse width, dev_hs, expected done, expected cur_code
    localparam int VEC [NV][4] = '{
        '{2,  0, 0, 0},
        '{3,  1, 0, 0},
        '{4,  0, 1, 2},
        '{8,  1, 1, 1},
        '{12, 0, 1, 2},
        '{13, 1, 1, 1},
        '{16, 0, 1, 2},
        '{17, 1, 0, 0},
        '{25, 0, 0, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, chg_en = 1'b0, ded_mode = 1'b0;
    logic       dev_attached = 1'b0, dp_det = 1'b0, dev_hs = 1'b0, bus_susp = 1'b0;
    logic       dm_src_en, neg_done, dpdm_short;
    logic [1:0] cur_code;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    chg_port_ctrl #(.MIN_W(MIN_W), .HOLD_MAX(HOLD_MAX), .MAX_W(MAX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .chg_en(chg_en),
        .ded_mode(ded_mode), .dev_attached(dev_attached), .dp_det(dp_det),
        .dev_hs(dev_hs), .bus_susp(bus_susp), .dm_src_en(dm_src_en),
        .neg_done(neg_done), .cur_code(cur_code), .dpdm_short(dpdm_short)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Drive a D+ pulse of p sampled edges and check the outcome.
    task automatic pulse(input int p, input int exp_done, input int exp_code);
        dp_det = 1'b1;
        step();
        check("R2 dm on after D+ seen", int'(dm_src_en), 1);
        repeat (p - 1) step();
        check("R3 dm at end of pulse", int'(dm_src_en),
              int'(p <= HOLD_MAX && p <= MAX_W));
        dp_det = 1'b0;
        step();
        check("R3 dm off after D+ low", int'(dm_src_en), 0);
        check("R5 neg_done", int'(neg_done), exp_done);
        check("R6 cur_code", int'(cur_code), exp_code);
    endtask

    task automatic to_idle();
        chg_en = 1'b0;
        step();
        chg_en = 1'b1;
        step();
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        step();
        step();
        check("R1 reset dm", int'(dm_src_en), 0);
        check("R1 reset done", int'(neg_done), 0);
        check("R1 reset code", int'(cur_code), 0);
        check("R1 reset short", int'(dpdm_short), 0);
        rst_n = 1'b1;
        port_en = 1'b1;
        chg_en = 1'b1;
        dev_attached = 1'b1;
        step();
        check("R1 after reset code", int'(cur_code), 0);

        for (int i = 0; i < NV; i++) begin
            dev_hs = VEC[i][1][0];
            pulse(VEC[i][0], VEC[i][2], VEC[i][3]);
            to_idle();
        end

        // R6: code follows speed live
        dev_hs = 1'b0;
        pulse(6, 1, 2);
        dev_hs = 1'b1;
        step();
        check("R6 code tracks dev_hs", int'(cur_code), 1);

        // R8: new D+ level after grant restarts handshake
        dp_det = 1'b1;
        step();
        check("R8 grant cleared on new D+", int'(neg_done), 0);
        check("R8 code cleared on new D+", int'(cur_code), 0);
        check("R8 dm on again", int'(dm_src_en), 1);
        repeat (5) step();
        dp_det = 1'b0;
        step();
        check("R8 regrant", int'(neg_done), 1);

        // R9: detach and port disable
        dev_attached = 1'b0;
        step();
        check("R9 detach clears code", int'(cur_code), 0);
        check("R9 detach clears done", int'(neg_done), 0);
        dev_attached = 1'b1;
        step();
        pulse(6, 1, 1);
        port_en = 1'b0;
        step();
        check("R9 port off clears code", int'(cur_code), 0);
        port_en = 1'b1;

        // R4: charging disabled never drives D-
        chg_en = 1'b0;
        dp_det = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 20; k++) begin
                step();
                seen = seen | int'(dm_src_en) | int'(neg_done);
            end
            check("R4 no D- drive while disabled", seen, 0);
        end
        dp_det = 1'b0;
        step();
        check("R4 no grant while disabled", int'(cur_code), 0);

        // R7: dedicated mode wins over charging mode
        chg_en = 1'b1;
        ded_mode = 1'b1;
        step();
        check("R7 short on", int'(dpdm_short), 1);
        check("R7 code 1.5A", int'(cur_code), 2);
        check("R7 no done", int'(neg_done), 0);
        dp_det = 1'b1;
        step();
        step();
        check("R7 no D- drive in dedicated", int'(dm_src_en), 0);
        dp_det = 1'b0;
        ded_mode = 1'b0;
        step();
        check("R7 short off on exit", int'(dpdm_short), 0);
        check("R7 code none on exit", int'(cur_code), 0);

        // R10: suspend does not disturb charging
        bus_susp = 1'b1;
        dev_hs = 1'b1;
        pulse(8, 1, 1);
        repeat (4) step();
        check("R10 grant held in suspend", int'(neg_done), 1);
        check("R10 code held in suspend", int'(cur_code), 1);

        summary();
    end
endmodule